// File: doc/BRIEF.md
# Boot-Overlay Memory Decoder

This block sits between a CPU that issues byte addresses on a 16-bit word bus and the memories it reaches. For each request it selects one of three targets: a local read-only program store, a small local read/write RAM, or off-board main memory. It also sets the two byte-lane enables of the 16-bit local bus. Word accesses must be even-addressed. For a byte access, an even address selects the high byte of the word and an odd address selects the low byte.

An 8-bit configuration register is reached through a one-cycle I/O strobe.

- Its low nibble is writable and clears on reset:
  - bit 0 disables the local overlay,
  - bit 1 enables the MMU,
  - bit 2 enables segmented user mode,
  - bit 3 enables the ECC-error NMI.
- Its high nibble always reads the four external switch inputs.

After reset the overlay is armed. In segment zero, addresses 0x0000–0x1FFF are served by the ROM and 0x2000–0x27FF by the RAM. Once software sets bit 0, every reference goes to main memory. Local RAM is never selected while the overlay is off, so its contents are left untouched.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset, the control nibble is 0000, the overlay is active, the MMU, segmented-user and NMI enables are low, and with no request no chip select is asserted.
- R2: With the overlay active, a read in segment 0 at an address from 0x0000 to 0x1FFF asserts only the ROM select.
- R3: With the overlay active, a read or write, byte or word, in segment 0 at an address from 0x2000 to 0x27FF asserts only the RAM select.
- R4: An address of 0x2800 or above, or any non-zero segment, asserts only the main-memory select.
- R5: When control bit 0 is 1, every aligned request asserts only the main-memory select, including writes to 0x0000–0x1FFF, and raises no write error.
- R6: For any selected access, a word access asserts both lanes. A byte access at an even address asserts only the high lane. A byte access at an odd address asserts only the low lane.
- R7: A word access with address bit 0 set raises the alignment-error flag for that cycle and asserts no chip select and no lane.
- R8: An aligned write to 0x0000–0x1FFF in segment 0 while the overlay is active raises the write-error flag for that cycle and asserts no chip select.
- R9: An I/O write loads bits 3:0 of the data into the control nibble and ignores bits 7:4. The read data is always {switch[3:0], control[3:0]}. A strobe without write enable changes nothing.
- R10: Control bits 1, 2 and 3 drive the MMU, segmented-user and NMI enable outputs. The overlay-active output is the inverse of bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Memory request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| seg_i | input | 7 | Segment number |
| addr_i | input | 16 | Byte address within segment |
| io_stb_i | input | 1 | One-cycle configuration port strobe |
| io_we_i | input | 1 | Configuration port write enable |
| io_wdata_i | input | 8 | Configuration write data |
| io_rdata_o | output | 8 | {switch, control} read data |
| switch_i | input | 4 | External switch inputs |
| rom_cs_o | output | 1 | Local ROM select |
| ram_cs_o | output | 1 | Local RAM select |
| main_cs_o | output | 1 | Main memory select |
| lane_hi_o | output | 1 | High (even) byte lane enable |
| lane_lo_o | output | 1 | Low (odd) byte lane enable |
| align_err_o | output | 1 | Misaligned word access |
| wr_err_o | output | 1 | Write to ROM while overlay active |
| local_en_o | output | 1 | Overlay active |
| mmu_en_o | output | 1 | MMU enable |
| seg_user_en_o | output | 1 | Segmented-user enable |
| nmi_en_o | output | 1 | ECC-error NMI enable |

## Verification
On every cycle the assertions check the following:
- at most one chip select is active;
- an alignment or write error never coincides with a select;
- a disabled overlay never selects local memory;
- byte accesses drive exactly one lane;
- the control nibble changes only on an I/O write, and then to the written value.

Only the bench's scenarios can show that the region boundaries (0x1FFF/0x2000, 0x27FF/0x2800) and the non-zero segments fall on the right side. The same is true of the read-data packing with live switch values and of re-arming the overlay after it has been disabled.

// File: rtl/bod_pkg.sv
package bod_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned SW_W   = 4;

  typedef struct packed {
    logic nmi_en;
    logic seg_user_en;
    logic mmu_en;
    logic local_dis;
  } ctrl_t;
endpackage

// File: rtl/bod_cfg_reg.sv
module bod_cfg_reg
  import bod_pkg::*;
#(
  parameter int unsigned SWW = SW_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_stb_i,
  input  logic                 io_we_i,
  input  logic [SWW+CTRL_W-1:0] io_wdata_i,
  input  logic [SWW-1:0]       switch_i,
  output logic [SWW+CTRL_W-1:0] io_rdata_o,
  output ctrl_t                ctrl_o
);
  logic  io_wr;
  ctrl_t ctrl_q;

  assign io_wr = io_stb_i & io_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= '0;
    else if (io_wr) ctrl_q <= ctrl_t'(io_wdata_i[CTRL_W-1:0]);
  end

  assign io_rdata_o = {switch_i, ctrl_q};
  assign ctrl_o     = ctrl_q;

  // R9
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr |=> ctrl_o == $past(io_wdata_i[CTRL_W-1:0]));
  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr |=> $stable(ctrl_o));
endmodule

// File: rtl/bod_addr_decode.sv
module bod_addr_decode
  import bod_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_END = 16'h2000,
  parameter logic [ADDR_W-1:0] RAM_END = 16'h2800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              local_on_i,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic              main_cs_o,
  output logic              align_err_o,
  output logic              wr_err_o
);
  logic misalign, hit_local, hit_rom, ok;

  assign misalign  = word_i & addr_i[0];
  assign hit_local = local_on_i & (seg_i == '0) & (addr_i < RAM_END);
  assign hit_rom   = hit_local & (addr_i < ROM_END);

  assign align_err_o = req_i & misalign;
  assign wr_err_o    = req_i & ~misalign & hit_rom & we_i;
  assign ok          = req_i & ~misalign;

  assign rom_cs_o  = ok & hit_rom & ~we_i;
  assign ram_cs_o  = ok & hit_local & ~hit_rom;
  assign main_cs_o = ok & ~hit_local;

  // R4
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ram_cs_o, main_cs_o}));
  // R7
  align_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !(rom_cs_o | ram_cs_o | main_cs_o));
  // R8
  wr_err_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> !(rom_cs_o | ram_cs_o | main_cs_o) && !align_err_o);
  // R5
  overlay_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !local_on_i |-> !rom_cs_o && !ram_cs_o && !wr_err_o);
endmodule

// File: rtl/bod_lane_sel.sv
module bod_lane_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic word_i,
  input  logic a0_i,
  output logic hi_o,
  output logic lo_o
);
  // even byte address is the most significant byte
  assign hi_o = sel_i & (word_i | ~a0_i);
  assign lo_o = sel_i & (word_i |  a0_i);

  // R6
  byte_one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !word_i) |-> $countones({hi_o, lo_o}) == 1);
  // R7
  idle_no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !hi_o && !lo_o);
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_stb_i,
  input  logic              io_we_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic [SW_W-1:0]   switch_i,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic              main_cs_o,
  output logic              lane_hi_o,
  output logic              lane_lo_o,
  output logic              align_err_o,
  output logic              wr_err_o,
  output logic              local_en_o,
  output logic              mmu_en_o,
  output logic              seg_user_en_o,
  output logic              nmi_en_o
);
  ctrl_t ctrl;
  logic  rom_cs, ram_cs, main_cs;

  bod_cfg_reg #(.SWW(SW_W)) u_cfg (
    .clk_i, .rst_ni, .io_stb_i, .io_we_i, .io_wdata_i, .switch_i,
    .io_rdata_o, .ctrl_o(ctrl)
  );

  bod_addr_decode u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .word_i, .seg_i, .addr_i,
    .local_on_i(~ctrl.local_dis),
    .rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .main_cs_o(main_cs),
    .align_err_o, .wr_err_o
  );

  bod_lane_sel u_lane (
    .clk_i, .rst_ni, .sel_i(rom_cs | ram_cs | main_cs), .word_i,
    .a0_i(addr_i[0]), .hi_o(lane_hi_o), .lo_o(lane_lo_o)
  );

  assign rom_cs_o      = rom_cs;
  assign ram_cs_o      = ram_cs;
  assign main_cs_o     = main_cs;
  assign local_en_o    = ~ctrl.local_dis;
  assign mmu_en_o      = ctrl.mmu_en;
  assign seg_user_en_o = ctrl.seg_user_en;
  assign nmi_en_o      = ctrl.nmi_en;

  // R10
  enables_follow_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {nmi_en_o, seg_user_en_o, mmu_en_o, ~local_en_o} == io_rdata_o[3:0]);
endmodule

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;
  logic clk = 0, rst_ni = 0;
  always #10 clk = ~clk;

  logic req = 0, we = 0, word = 0, io_stb = 0, io_we = 0;
  logic [6:0] seg = '0;
  logic [15:0] addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [3:0] sw = 4'hA;
  logic rom_cs, ram_cs, main_cs, hi, lo, aerr, werr, local_en, mmu_en, su_en, nmi_en;

  int checks = 0, failures = 0;
  bit done = 0;

  boot_overlay_decoder dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .word_i(word), .seg_i(seg),
    .addr_i(addr), .io_stb_i(io_stb), .io_we_i(io_we), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .switch_i(sw), .rom_cs_o(rom_cs), .ram_cs_o(ram_cs),
    .main_cs_o(main_cs), .lane_hi_o(hi), .lane_lo_o(lo), .align_err_o(aerr),
    .wr_err_o(werr), .local_en_o(local_en), .mmu_en_o(mmu_en),
    .seg_user_en_o(su_en), .nmi_en_o(nmi_en)
  );

  // outs order: rom, ram, main, hi, lo, align_err, wr_err
  typedef struct packed {
    logic [3:0]  tag;
    logic [3:0]  ctrl;
    logic        we;
    logic        word;
    logic [6:0]  seg;
    logic [15:0] addr;
    logic [6:0]  exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  4'h0, 1'b0, 1'b1, 7'd0,   16'h0000, 7'b1001100}, // R2
    '{4'd2,  4'h0, 1'b0, 1'b0, 7'd0,   16'h1FFF, 7'b1000100}, // R2
    '{4'd3,  4'h0, 1'b1, 1'b1, 7'd0,   16'h2000, 7'b0101100}, // R3
    '{4'd3,  4'h0, 1'b1, 1'b0, 7'd0,   16'h27FF, 7'b0100100}, // R3
    '{4'd6,  4'h0, 1'b0, 1'b0, 7'd0,   16'h2400, 7'b0101000}, // R6
    '{4'd4,  4'h0, 1'b0, 1'b1, 7'd0,   16'h2800, 7'b0011100}, // R4
    '{4'd4,  4'h0, 1'b0, 1'b1, 7'd1,   16'h0010, 7'b0011100}, // R4
    '{4'd4,  4'h0, 1'b1, 1'b0, 7'h7F,  16'h2101, 7'b0010100}, // R4
    '{4'd7,  4'h0, 1'b0, 1'b1, 7'd0,   16'h0101, 7'b0000010}, // R7
    '{4'd7,  4'h0, 1'b1, 1'b1, 7'd0,   16'h2003, 7'b0000010}, // R7
    '{4'd8,  4'h0, 1'b1, 1'b1, 7'd0,   16'h0100, 7'b0000001}, // R8
    '{4'd8,  4'h0, 1'b1, 1'b0, 7'd0,   16'h1FFF, 7'b0000001}, // R8
    '{4'd5,  4'h1, 1'b0, 1'b1, 7'd0,   16'h0000, 7'b0011100}, // R5
    '{4'd5,  4'h1, 1'b1, 1'b0, 7'd0,   16'h2001, 7'b0010100}, // R5
    '{4'd5,  4'h1, 1'b1, 1'b1, 7'd0,   16'h0200, 7'b0011100}, // R5
    '{4'd7,  4'h1, 1'b0, 1'b1, 7'd0,   16'h2801, 7'b0000010}, // R7
    '{4'd3,  4'h0, 1'b0, 1'b1, 7'd0,   16'h2002, 7'b0101100}  // R3 re-armed
  };

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] d);
    @(negedge clk);
    io_stb = 1; io_we = 1; io_wdata = d;
    @(negedge clk);
    io_stb = 0; io_we = 0; io_wdata = '0;
  endtask

  function automatic logic [6:0] outs();
    return {rom_cs, ram_cs, main_cs, hi, lo, aerr, werr};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #5;
    // R1 reset state
    check("R1", {28'd0, io_rdata[3:0]}, 32'h0);
    check("R1", {28'd0, local_en, mmu_en, su_en, nmi_en}, 32'h8);
    check("R1", {25'd0, outs()}, 32'h0);
    rst_ni = 1;
    @(negedge clk); #5;
    check("R1", {25'd0, outs()}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      io_write({4'h0, VECS[i].ctrl});
      req = 1; we = VECS[i].we; word = VECS[i].word;
      seg = VECS[i].seg; addr = VECS[i].addr;
      #5;
      check($sformatf("R%0d vec%0d", VECS[i].tag, i), {25'd0, outs()}, {25'd0, VECS[i].exp});
      @(negedge clk);
      req = 0; we = 0; word = 0; seg = '0; addr = '0;
    end

    // R9 high nibble of write ignored, read packs live switches
    io_write(8'h5E);
    #5;
    check("R9", {24'd0, io_rdata}, 32'hAE);
    sw = 4'h3; #1;
    check("R9", {24'd0, io_rdata}, 32'h3E);
    // R10 enables follow control bits
    check("R10", {28'd0, local_en, mmu_en, su_en, nmi_en}, 32'hF);
    // R9 strobe without write enable changes nothing
    @(negedge clk);
    io_stb = 1; io_we = 0; io_wdata = 8'h01;
    @(negedge clk);
    io_stb = 0; #5;
    check("R9", {24'd0, io_rdata}, 32'h3E);
    // R10 overlay bit alone
    io_write(8'h01);
    #5;
    check("R10", {28'd0, local_en, mmu_en, su_en, nmi_en}, 32'h0);
    // R1 asynchronous reset clears control
    io_write(8'h0F);
    #3; rst_ni = 0; #2;
    check("R1", {24'd0, io_rdata}, 32'h30);
    @(negedge clk); rst_ni = 1;
    // R2 overlay re-armed after reset
    req = 1; addr = 16'h0002; word = 1; #5;
    check("R2", {25'd0, outs()}, 32'b1001100);
    req = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule